// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks divider settings for a clock synthesiser whose reference is fixed at 12288 kHz. A requested output frequency, given in kHz, is captured on a start strobe. The engine then walks the post-divider exponent P and the input divider N in a fixed order. For each pair it derives the feedback divider M that puts the output just at or below the request, and it keeps the legal candidate whose output lies closest to the request.

The walk is done by a small state machine around one shift-subtract divider that gives one quotient bit per cycle. The divider is used twice for each candidate: once to find M, and once to find the output frequency the candidate would produce. The phase-comparator and VCO bounds are checked with multiplications instead of further divisions. The result is a packed settings word, a one-cycle done pulse and a no-fit flag.

Top module: `pll_div_search`

## Requirements
- R1: After reset, `busy`, `done` and `no_fit` are 0 and `pll_word` is 0.
- R2: The search visits P = 0..4 in the outer order and N = 0..31 in the inner order. Each candidate has divisor d = (N+1)<<P, quotient q = floor(req*d/12288) and M = q-1. Its output frequency is floor(12288*q/d).
- R3: A candidate is legal only when all three of these hold: M >= 40; floor(12288/(N+1)) >= 1000; floor(12288*(M+1)/(N+1)) lies in 170000..340000 inclusive.
- R4: The best error starts at 12288. A legal candidate with |req - output| less than or equal to the best error replaces the stored best, so among equal errors the last one visited wins.
- R5: Once M exceeds 255 for some N, the remaining N values for that P are skipped and the search moves to the next P.
- R6: `pll_word` packs M in bits 15:8, N in bits 7:3 and P in bits 2:0.
- R7: When no candidate is legal, `no_fit` is 1 and `pll_word` is 0. Otherwise `no_fit` is 0.
- R8: A `start` pulse while `busy` is high is ignored. The running search keeps its captured request and produces exactly one `done`.
- R9: `busy` rises in the cycle after `start` is sampled in idle. `done` is high for exactly one cycle, and `busy` is low in that same cycle.
- R10: `pll_word` and `no_fit` change only on the cycle that `done` is raised. They hold between searches and while a new search is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; sampled only when idle |
| req_khz | input | 20 | Requested output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| no_fit | output | 1 | No legal candidate was found |
| pll_word | output | 16 | Packed M, N and P settings |

## Verification
`busy` is due one cycle after the start strobe is sampled. The bench reads it at the next falling edge. The `done` pulse arrives after a sweep whose length depends on the request: each visited candidate costs one cycle to set up, one full divider pass for M, one cycle to test it and, if legal, a second divider pass and one cycle to score it. For that reason the bench polls `done` at every falling edge and does not use a fixed delay. It reads `pll_word` and `no_fit` in the same sample as `done`, then checks that `done` has fallen one sample later. Each expected word comes from an exhaustive integer model of the search order and the legality rules.

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int REF_KHZ     = 12288,
  parameter int REQ_W       = 20,
  parameter int P_MAX       = 4,
  parameter int N_MAX       = 31,
  parameter int M_MIN       = 40,
  parameter int M_MAX       = 255,
  parameter int PFD_MIN_KHZ = 1000,
  parameter int VCO_MIN_KHZ = 170000,
  parameter int VCO_MAX_KHZ = 340000,
  parameter int M_W         = 8,
  parameter int N_W         = 5,
  parameter int P_W         = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [REQ_W-1:0]         req_khz,
  output logic                     busy,
  output logic                     done,
  output logic                     no_fit,
  output logic [M_W+N_W+P_W-1:0]   pll_word
);

  localparam int D_W    = $clog2((N_MAX + 1) << P_MAX) + 1;
  localparam int DV_W   = REQ_W + D_W;
  localparam int CNT_W  = $clog2(DV_W + 1);
  localparam int Q_W    = M_W + 1;
  localparam int WORD_W = M_W + N_W + P_W;

  typedef enum logic [2:0] {S_IDLE, S_CAND, S_DIVQ, S_TEST, S_DIVO, S_SCORE} state_t;

  state_t             state;
  logic [P_W-1:0]     p_q;
  logic [N_W-1:0]     n_q;
  logic [REQ_W-1:0]   req_r;
  logic [DV_W:0]      dv_rem;
  logic [DV_W-1:0]    dv_quo;
  logic [DV_W-1:0]    dv_den;
  logic [CNT_W-1:0]   dv_cnt;
  logic [Q_W-1:0]     cand_q;
  logic [31:0]        best_err;
  logic [Q_W-1:0]     best_q;
  logic [N_W-1:0]     best_n;
  logic [P_W-1:0]     best_p;
  logic               found;
  logic [WORD_W-1:0]  word_r;
  logic               nofit_r;
  logic               done_r;

  // candidate geometry
  logic [D_W-1:0] n_inc, cur_d;
  logic [31:0]    n_plus;
  logic           pfd_ok;
  assign n_inc  = {{(D_W-N_W){1'b0}}, n_q} + D_W'(1);
  assign cur_d  = n_inc << p_q;
  assign n_plus = 32'(n_q) + 32'd1;
  assign pfd_ok = 32'(REF_KHZ) >= 32'(PFD_MIN_KHZ) * n_plus;

  // one restoring divider step per cycle
  logic [DV_W:0]   rem_sh, rem_nx;
  logic [DV_W-1:0] quo_nx;
  logic            sub_ok, dv_last;
  assign rem_sh  = {dv_rem[DV_W-1:0], dv_quo[DV_W-1]};
  assign sub_ok  = rem_sh >= {1'b0, dv_den};
  assign rem_nx  = sub_ok ? rem_sh - {1'b0, dv_den} : rem_sh;
  assign quo_nx  = {dv_quo[DV_W-2:0], sub_ok};
  assign dv_last = dv_cnt == CNT_W'(DV_W - 1);

  // candidate test, dv_quo holds q in S_TEST
  logic        q_over, m_ok, vco_ok;
  logic [31:0] ref_q;
  assign q_over = dv_quo > DV_W'(M_MAX + 1);
  assign m_ok   = dv_quo >= DV_W'(M_MIN + 1);
  assign ref_q  = 32'(REF_KHZ) * 32'(dv_quo[Q_W-1:0]);
  assign vco_ok = (ref_q >= 32'(VCO_MIN_KHZ) * n_plus) &&
                  (ref_q <  32'(VCO_MAX_KHZ + 1) * n_plus);

  // scoring, dv_quo holds output frequency in S_SCORE
  logic [31:0] out_f, req_f, err;
  logic        take;
  assign out_f = 32'(dv_quo);
  assign req_f = 32'(req_r);
  assign err   = (req_f > out_f) ? req_f - out_f : out_f - req_f;
  assign take  = (state == S_SCORE) && (err <= best_err);

  // sweep stepping
  logic go_p, go_n, wrap_p, finish;
  always_comb begin
    go_p = 1'b0;
    go_n = 1'b0;
    case (state)
      S_CAND:  go_p = !pfd_ok;
      S_TEST:  begin
                 if (q_over) go_p = 1'b1;
                 else if (!(m_ok && vco_ok)) go_n = 1'b1;
               end
      S_SCORE: go_n = 1'b1;
      default: ;
    endcase
  end
  assign wrap_p = go_p || (go_n && n_q == N_W'(N_MAX));
  assign finish = wrap_p && p_q == P_W'(P_MAX);

  logic [Q_W-1:0] fin_q;
  logic [N_W-1:0] fin_n;
  logic [P_W-1:0] fin_p;
  logic           fin_found;
  logic [Q_W-1:0] fin_m;
  assign fin_q     = take ? cand_q : best_q;
  assign fin_n     = take ? n_q    : best_n;
  assign fin_p     = take ? p_q    : best_p;
  assign fin_found = take || found;
  assign fin_m     = fin_q - Q_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      p_q      <= '0;
      n_q      <= '0;
      req_r    <= '0;
      dv_rem   <= '0;
      dv_quo   <= '0;
      dv_den   <= '0;
      dv_cnt   <= '0;
      cand_q   <= '0;
      best_err <= '0;
      best_q   <= '0;
      best_n   <= '0;
      best_p   <= '0;
      found    <= 1'b0;
      word_r   <= '0;
      nofit_r  <= 1'b0;
      done_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          req_r    <= req_khz;
          p_q      <= '0;
          n_q      <= '0;
          best_err <= 32'(REF_KHZ);
          found    <= 1'b0;
          state    <= S_CAND;
        end
        S_CAND: if (pfd_ok) begin
          dv_rem <= '0;
          dv_quo <= DV_W'(req_r) * DV_W'(cur_d);
          dv_den <= DV_W'(REF_KHZ);
          dv_cnt <= '0;
          state  <= S_DIVQ;
        end
        S_DIVQ, S_DIVO: begin
          dv_rem <= rem_nx;
          dv_quo <= quo_nx;
          dv_cnt <= dv_cnt + CNT_W'(1);
          if (dv_last) state <= (state == S_DIVQ) ? S_TEST : S_SCORE;
        end
        S_TEST: if (!q_over && m_ok && vco_ok) begin
          cand_q <= dv_quo[Q_W-1:0];
          dv_rem <= '0;
          dv_quo <= DV_W'(ref_q);
          dv_den <= DV_W'(cur_d);
          dv_cnt <= '0;
          state  <= S_DIVO;
        end
        S_SCORE: if (take) begin
          best_err <= err;
          best_q   <= cand_q;
          best_n   <= n_q;
          best_p   <= p_q;
          found    <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase

      if (finish) begin
        state   <= S_IDLE;
        done_r  <= 1'b1;
        nofit_r <= !fin_found;
        word_r  <= fin_found ? {fin_m[M_W-1:0], fin_n, fin_p} : '0;
      end else if (wrap_p) begin
        p_q   <= p_q + P_W'(1);
        n_q   <= '0;
        state <= S_CAND;
      end else if (go_n) begin
        n_q   <= n_q + N_W'(1);
        state <= S_CAND;
      end
    end
  end

  assign busy     = state != S_IDLE;
  assign done     = done_r;
  assign no_fit   = nofit_r;
  assign pll_word = word_r;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  p_nofit_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    no_fit |-> pll_word == '0);
  p_m_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_fit) |-> pll_word[WORD_W-1 -: M_W] >= M_W'(M_MIN));
  p_p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pll_word[P_W-1:0] <= P_W'(P_MAX));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || ($stable(pll_word) && $stable(no_fit))));
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !finish) |=> busy);

endmodule

// File: tb/pll_div_search_bench.sv
module pll_div_search_bench;
  localparam int REF = 12288;
  localparam int NV  = 12;
  localparam int VEC_REQ [NV]  = '{25175, 40000, 65000, 12288, 50000, 100000,
                                   170000, 340000, 11000, 5000, 400000, 33333};
  localparam bit VEC_NOFIT [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] req_khz = '0;
  logic        busy, done, no_fit;
  logic [15:0] pll_word;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pll_div_search u_pll_div_search (
    .clk(clk), .rst_n(rst_n), .start(start), .req_khz(req_khz),
    .busy(busy), .done(done), .no_fit(no_fit), .pll_word(pll_word)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input int req, output logic [15:0] w, output bit nf);
    int e, q, m, d, outf, vco, err;
    bit fnd;
    int bm, bn, bp;
    e = REF; fnd = 0; bm = 0; bn = 0; bp = 0;
    for (int p = 0; p <= 4; p++) begin
      for (int n = 0; n < 32; n++) begin
        d = (n + 1) << p;
        q = (req * d) / REF;
        m = q - 1;
        outf = (REF * q) / d;
        if (m > 255) break;
        vco = (REF * q) / (n + 1);
        err = (req > outf) ? req - outf : outf - req;
        if (m >= 40 && REF / (n + 1) >= 1000 && vco >= 170000 && vco <= 340000 && err <= e) begin
          e = err; bm = m; bn = n; bp = p; fnd = 1;
        end
      end
    end
    nf = !fnd;
    w = fnd ? {bm[7:0], bn[4:0], bp[2:0]} : 16'h0;
  endfunction

  task automatic launch(input int req);
    @(negedge clk);
    start = 1'b1;
    req_khz = 20'(req);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output logic [15:0] w, output bit nf);
    int cyc = 0;
    while (!done && cyc < 10000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R9 done arrives", int'(done), 1);
    chk(!busy, "R9 busy low with done", int'(busy), 0);
    w = pll_word;
    nf = no_fit;
    @(negedge clk);
    chk(!done, "R9 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w, ew;
    bit nf, enf;
    int m, n, p, vco, dcount;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !no_fit, "R1 reset flags", {busy, done, no_fit}, 0);
    chk(pll_word == 0, "R1 reset word", pll_word, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      model(VEC_REQ[i], ew, enf);
      launch(VEC_REQ[i]);
      chk(busy, "R9 busy after start", int'(busy), 1);
      wait_done(w, nf);
      chk(w == ew, "R2 R4 R5 R6 word", w, ew);
      chk(nf == VEC_NOFIT[i], "R7 no_fit", nf, VEC_NOFIT[i]);
      if (nf) chk(w == 0, "R7 zero word", w, 0);
      else begin
        m = w[15:8]; n = w[7:3]; p = w[2:0];
        vco = (REF * (m + 1)) / (n + 1);
        chk(m >= 40, "R3 M floor", m, 40);
        chk(REF / (n + 1) >= 1000, "R3 phase comparator", REF / (n + 1), 1000);
        chk(vco >= 170000 && vco <= 340000, "R3 VCO range", vco, 170000);
        chk(p <= 4, "R6 P field", p, 4);
      end
      repeat (5) @(negedge clk);
      chk(pll_word == w && no_fit == nf, "R10 hold", pll_word, w);
    end

    model(65000, ew, enf);
    launch(65000);
    repeat (100) @(negedge clk);
    chk(pll_word == w, "R10 hold during search", pll_word, w);
    start = 1'b1;
    req_khz = 20'd25175;
    @(negedge clk);
    start = 1'b0;
    wait_done(w, nf);
    chk(w == ew, "R8 start ignored while busy", w, ew);
    dcount = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (done) dcount++;
    end
    chk(dcount == 0 && !busy, "R8 single done", dcount, 0);

    launch(40000);
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !no_fit && pll_word == 0, "R1 reset mid search", pll_word, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule